// File: doc/BRIEF.md
# Event Interrupt Flag Register

This block holds eight bits of interrupt request state at one byte address of a CPU bus. Six of the bits are latched by single-cycle event strobes from the peripherals around it: an A/D conversion finishing, a direct power-mode transition, a timer capture-pin edge, a timer counter wrapping in either direction, and the compare matches of a timer that runs as two 8-bit channels or as one 16-bit channel. Once set, a flag stays set and drives a level request toward the interrupt controller until software clears it.

Software can clear an event flag but can never set one. It clears a flag by writing 0 to that bit. Writing 1 to a bit leaves it as it is, so a read-modify-write that puts back a 1 cannot lose an event. One bit is ordinary read/write storage with no hardware source. The lowest bit is reserved.

The timer mode input selects which compare strobes are counted. In 8-bit mode the high-channel and low-channel matches each set their own flag. In 16-bit mode only the combined match is counted, and it lands on the high-channel flag.

Top module: `evt_irq_flags`

## Requirements
- R1: After reset, every flag output and every bit read back at the register address is 0.
- R2: A one-cycle strobe on ev_dtrans, ev_adc_done, ev_tg_edge or ev_tc_wrap sets bit 7, 6, 4 or 1 respectively on the next clock edge, and the bit stays set with no further strobe.
- R3: A write to the register address clears each of bits 7, 6 and 4..1 whose written value is 0. A bit written with 1 keeps its value.
- R4: Writing 1 to bit 7, 6, 4, 3, 2 or 1 while it is 0 leaves it 0.
- R5: Bit 5 takes the written value on every write to the register address and holds it otherwise.
- R6: Bit 0 always reads 0 and drives 0, whatever is written.
- R7: With wide_mode=0, ev_cmp_hi sets bit 3 and ev_cmp_lo sets bit 2, while ev_cmp_wide has no effect.
- R8: With wide_mode=1, ev_cmp_wide sets bit 3, while ev_cmp_hi and ev_cmp_lo have no effect.
- R9: If a set strobe and a written 0 reach the same bit in the same cycle, the bit ends up 1.
- R10: A write to any address other than REG_ADDR (default 8'hF7) changes no flag.
- R11: bus_rdata equals the flag vector while bus_addr is REG_ADDR and is 0 at any other address. Reads have no side effects, and irq_out always shows the flag vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | CPU bus byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ev_dtrans | input | 1 | Direct power-mode transition taken |
| ev_adc_done | input | 1 | A/D conversion finished |
| ev_tg_edge | input | 1 | Selected edge seen on timer capture pin |
| ev_cmp_hi | input | 1 | High 8-bit counter matched its compare value |
| ev_cmp_lo | input | 1 | Low 8-bit counter matched its compare value |
| ev_cmp_wide | input | 1 | Combined 16-bit counter matched combined compare value |
| wide_mode | input | 1 | 1 selects 16-bit timer mode, 0 selects 8-bit mode |
| ev_tc_wrap | input | 1 | Timer counter overflow or underflow |
| irq_out | output | 8 | Level interrupt requests, one per flag bit |

## Verification
The bench targets a write of 0 that coincides with a set strobe. A design that lets the clear win drops that event, and bit 1 reads 0 when it should read 1. It writes 1 to clear flags, which catches a design that treats the bus write as plain storage and so lets software raise a request it never saw. It drives every compare strobe in both timer modes, which exposes a design that still counts the low match or the 8-bit high match in 16-bit mode, or one that ignores the mode. It writes to a neighbouring address and a read-modify-write pattern to bits 5 and 0, which catches a loose address decode, a set-only bit 5 and a reserved bit that holds data.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   typedef enum logic [1:0] {
      FK_CLR_ONLY = 2'd0,
      FK_PLAIN    = 2'd1,
      FK_RSVD     = 2'd2
   } flag_kind_e;

   localparam int FLAG_W     = 8;
   localparam int BIT_DTRANS = 7;
   localparam int BIT_ADC    = 6;
   localparam int BIT_USER   = 5;
   localparam int BIT_TG     = 4;
   localparam int BIT_CMP_HI = 3;
   localparam int BIT_CMP_LO = 2;
   localparam int BIT_TC     = 1;
   localparam int BIT_RSVD   = 0;

   function automatic flag_kind_e kind_of(input int idx);
      if (idx == BIT_USER)      return FK_PLAIN;
      else if (idx == BIT_RSVD) return FK_RSVD;
      else                      return FK_CLR_ONLY;
   endfunction

endpackage

// File: rtl/evt_flag_cell.sv
module evt_flag_cell
   import evt_irq_pkg::*;
#(
   parameter flag_kind_e KIND = FK_CLR_ONLY
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wr_bit,
   input  logic set_ev,
   output logic q
);

   generate
      if (KIND == FK_CLR_ONLY) begin : g_clr_only
         // the set strobe takes priority over a same-cycle written 0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 q <= 1'b0;
            else if (set_ev)            q <= 1'b1;
            else if (wr_hit && !wr_bit) q <= 1'b0;
         end
      end else if (KIND == FK_PLAIN) begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set_ev) q <= 1'b1;
            else if (wr_hit) q <= wr_bit;
         end
      end else begin : g_rsvd
         logic unused_rsvd;
         assign unused_rsvd = clk ^ rst_n ^ wr_hit ^ wr_bit ^ set_ev;
         assign q = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/evt_cmp_route.sv
module evt_cmp_route (
   input  logic wide_mode,
   input  logic cmp_hi,
   input  logic cmp_lo,
   input  logic cmp_wide,
   output logic set_hi,
   output logic set_lo
);

   always_comb begin
      if (wide_mode) begin
         set_hi = cmp_wide;
         set_lo = 1'b0;
      end else begin
         set_hi = cmp_hi;
         set_lo = cmp_lo;
      end
   end

endmodule

// File: rtl/evt_bus_dec.sv
module evt_bus_dec #(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hF7,
   parameter int                DATA_W   = 8
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] flags,
   output logic              wr_hit,
   output logic [DATA_W-1:0] bus_rdata
);

   logic sel;

   assign sel       = (bus_addr == REG_ADDR);
   assign wr_hit    = sel && bus_we;
   assign bus_rdata = sel ? flags : '0;

endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags
   import evt_irq_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hF7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              ev_dtrans,
   input  logic              ev_adc_done,
   input  logic              ev_tg_edge,
   input  logic              ev_cmp_hi,
   input  logic              ev_cmp_lo,
   input  logic              ev_cmp_wide,
   input  logic              wide_mode,
   input  logic              ev_tc_wrap,
   output logic [7:0]        irq_out
);

   localparam int W = FLAG_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("evt_irq_flags: ADDR_W out of range");
      end
      if (W != 8) begin : g_bad_flag_w
         $error("evt_irq_flags: flag width must be 8");
      end
   endgenerate

   logic         wr_hit;
   logic         set_hi;
   logic         set_lo;
   logic [W-1:0] set_vec;
   logic [W-1:0] flags;

   evt_cmp_route u_route (
      .wide_mode (wide_mode),
      .cmp_hi    (ev_cmp_hi),
      .cmp_lo    (ev_cmp_lo),
      .cmp_wide  (ev_cmp_wide),
      .set_hi    (set_hi),
      .set_lo    (set_lo)
   );

   always_comb begin
      set_vec             = '0;
      set_vec[BIT_DTRANS] = ev_dtrans;
      set_vec[BIT_ADC]    = ev_adc_done;
      set_vec[BIT_TG]     = ev_tg_edge;
      set_vec[BIT_CMP_HI] = set_hi;
      set_vec[BIT_CMP_LO] = set_lo;
      set_vec[BIT_TC]     = ev_tc_wrap;
   end

   evt_bus_dec #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .DATA_W   (W)
   ) u_dec (
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .flags     (flags),
      .wr_hit    (wr_hit),
      .bus_rdata (bus_rdata)
   );

   for (genvar i = 0; i < W; i++) begin : g_flag
      evt_flag_cell #(
         .KIND (kind_of(i))
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (wr_hit),
         .wr_bit (bus_wdata[i]),
         .set_ev (set_vec[i]),
         .q      (flags[i])
      );
   end

   assign irq_out = flags;

endmodule

// File: rtl/evt_irq_flags_chk.sv
module evt_irq_flags_chk #(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hF7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              ev_dtrans,
   input logic              ev_adc_done,
   input logic              ev_tg_edge,
   input logic              ev_cmp_hi,
   input logic              ev_cmp_lo,
   input logic              ev_cmp_wide,
   input logic              wide_mode,
   input logic              ev_tc_wrap,
   input logic [7:0]        irq_out
);

   logic hit_wr;
   logic any_ev;
   assign hit_wr = bus_we && (bus_addr == REG_ADDR);
   assign any_ev = ev_dtrans | ev_adc_done | ev_tg_edge | ev_cmp_hi |
                   ev_cmp_lo | ev_cmp_wide | ev_tc_wrap;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> irq_out == 8'h00);

   assert_adc_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_adc_done |=> irq_out[6]);

   assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && !bus_wdata[7] && !ev_dtrans) |=> !irq_out[7]);

   assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out[4] && !ev_tg_edge) |=> !irq_out[4]);

   assert_plain_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wr |=> irq_out[5] == $past(bus_wdata[5]));

   assert_lo_match_8bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_mode && ev_cmp_lo) |=> irq_out[2]);

   assert_hi_ignored_16bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_mode && !ev_cmp_wide && !irq_out[3]) |=> !irq_out[3]);

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tc_wrap |=> irq_out[1]);

   assert_other_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr != REG_ADDR && !any_ev) |=> $stable(irq_out));

   assert_read_mux_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != REG_ADDR) |-> bus_rdata == 8'h00);

endmodule

bind evt_irq_flags evt_irq_flags_chk #(
   .ADDR_W   (ADDR_W),
   .REG_ADDR (REG_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .ev_dtrans   (ev_dtrans),
   .ev_adc_done (ev_adc_done),
   .ev_tg_edge  (ev_tg_edge),
   .ev_cmp_hi   (ev_cmp_hi),
   .ev_cmp_lo   (ev_cmp_lo),
   .ev_cmp_wide (ev_cmp_wide),
   .wide_mode   (wide_mode),
   .ev_tc_wrap  (ev_tc_wrap),
   .irq_out     (irq_out)
);

// File: tb/tb_evt_irq_flags.sv
`timescale 1ns/1ps
module tb_evt_irq_flags;

   localparam logic [7:0] A = 8'hF7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = A;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ev_dtrans = 1'b0, ev_adc_done = 1'b0, ev_tg_edge = 1'b0;
   logic       ev_cmp_hi = 1'b0, ev_cmp_lo = 1'b0, ev_cmp_wide = 1'b0;
   logic       wide_mode = 1'b0, ev_tc_wrap = 1'b0;
   logic [7:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   evt_irq_flags dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_dtrans(ev_dtrans),
      .ev_adc_done(ev_adc_done), .ev_tg_edge(ev_tg_edge), .ev_cmp_hi(ev_cmp_hi),
      .ev_cmp_lo(ev_cmp_lo), .ev_cmp_wide(ev_cmp_wide), .wide_mode(wide_mode),
      .ev_tc_wrap(ev_tc_wrap), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   // one bus write, captured at the posedge between two negedges
   task automatic wr(input logic [7:0] addr, input logic [7:0] data);
      @(negedge clk);
      bus_addr = addr; bus_we = 1'b1; bus_wdata = data;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A;
   endtask

   // strobe selector: 0 dtrans 1 adc 2 tg 3 hi 4 lo 5 wide 6 tc
   task automatic pulse(input int sel);
      @(negedge clk);
      case (sel)
         0: ev_dtrans = 1'b1;
         1: ev_adc_done = 1'b1;
         2: ev_tg_edge = 1'b1;
         3: ev_cmp_hi = 1'b1;
         4: ev_cmp_lo = 1'b1;
         5: ev_cmp_wide = 1'b1;
         default: ev_tc_wrap = 1'b1;
      endcase
      @(negedge clk);
      {ev_dtrans, ev_adc_done, ev_tg_edge, ev_cmp_hi, ev_cmp_lo, ev_cmp_wide, ev_tc_wrap} = '0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 irq_out in reset", irq_out, 8'h00);
      chk("R1 rdata in reset", bus_rdata, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq_out after reset", irq_out, 8'h00);
   endtask

   task automatic t_events();
      pulse(0); chk("R2 dtrans sets bit7", irq_out, 8'h80);
      pulse(1); chk("R2 adc sets bit6", irq_out, 8'hC0);
      pulse(2); chk("R2 tg sets bit4", irq_out, 8'hD0);
      pulse(6); chk("R2 tc sets bit1", irq_out, 8'hD2);
      repeat (3) @(negedge clk);
      chk("R2 flags hold", irq_out, 8'hD2);
      chk("R11 read at reg addr", bus_rdata, 8'hD2);
      chk("R11 read no side effect", irq_out, 8'hD2);
   endtask

   task automatic t_clear();
      wr(A, 8'hDF); chk("R3 write ones keeps flags", irq_out, 8'hD2);
      wr(A, 8'h9F); chk("R3 zero clears bit6 only", irq_out, 8'h92);
      wr(A, 8'h00); chk("R3 zero clears all", irq_out, 8'h00);
   endtask

   task automatic t_noset();
      wr(A, 8'hFF); chk("R4 ones cannot set event flags", irq_out, 8'h20);
      chk("R5 bit5 written 1", bus_rdata, 8'h20);
      wr(A, 8'hDF); chk("R5 bit5 written 0", irq_out, 8'h00);
      wr(A, 8'h01); chk("R6 bit0 ignores write", irq_out, 8'h00);
      chk("R6 bit0 reads 0", bus_rdata, 8'h00);
   endtask

   task automatic t_mode8();
      wide_mode = 1'b0;
      pulse(5); chk("R7 wide match ignored in 8-bit mode", irq_out, 8'h00);
      pulse(3); chk("R7 hi match sets bit3", irq_out, 8'h08);
      pulse(4); chk("R7 lo match sets bit2", irq_out, 8'h0C);
      wr(A, 8'h00); chk("R3 clear timer flags", irq_out, 8'h00);
   endtask

   task automatic t_mode16();
      @(negedge clk); wide_mode = 1'b1;
      pulse(4); chk("R8 lo match ignored in 16-bit mode", irq_out, 8'h00);
      pulse(3); chk("R8 hi match ignored in 16-bit mode", irq_out, 8'h00);
      pulse(5); chk("R8 wide match sets bit3", irq_out, 8'h08);
      wr(A, 8'h00);
      @(negedge clk); wide_mode = 1'b0;
   endtask

   task automatic t_race();
      pulse(1);
      @(negedge clk);
      bus_we = 1'b1; bus_wdata = 8'h00; ev_tc_wrap = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; ev_tc_wrap = 1'b0;
      chk("R9 set beats clear on clear bit", irq_out, 8'h02);
      @(negedge clk);
      bus_we = 1'b1; bus_wdata = 8'h00; ev_tc_wrap = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; ev_tc_wrap = 1'b0;
      chk("R9 set beats clear on set bit", irq_out, 8'h02);
      wr(A, 8'h00); chk("R3 clear after race", irq_out, 8'h00);
   endtask

   task automatic t_addr();
      pulse(1);
      wr(8'hF6, 8'h00); chk("R10 other address no clear", irq_out, 8'h40);
      wr(8'hF8, 8'hFF); chk("R10 other address no bit5", irq_out, 8'h40);
      @(negedge clk); bus_addr = 8'hF6; #1;
      chk("R11 read elsewhere is 0", bus_rdata, 8'h00);
      bus_addr = A; #1;
      chk("R11 read at reg addr", bus_rdata, 8'h40);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_events();
      t_clear();
      t_noset();
      t_mode8();
      t_mode16();
      t_race();
      t_addr();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule